// File: doc/BRIEF.md
# Two-Wire Register Bank Slave with Pointer Auto-Increment

This block is a serial slave on a two-wire bus (a clock line and an open-drain data line). It holds sixteen 8-bit registers and lets a bus master read and write them. Both lines are sampled on the system clock. The block finds start and stop conditions and shifts bytes most significant bit first. It acknowledges by pulling the data line low, and it never drives the line high.

A write transfer carries three kinds of byte, in this order. The first is the device-address byte, with the read/write flag in bit 0. The second is a register-select byte. Its bit 7 must be set, bit 6 picks the pointer mode, bits 5:4 are ignored, and bits 3:0 give the register pointer. Data bytes follow. In step mode (bit 6 = 1), data bytes go to registers in sequence. In paired mode (bit 6 = 0), every data byte must be followed by a fresh register-select byte. Reads are started with a repeated start and a read-flagged device address. In step mode, a read advances the pointer before the register is fetched, except on the first read after a register-select byte. In paired mode, a read always returns the same register.

Top module: `regbank_serial_slave`

## Requirements
- R1: A device-address byte whose upper seven bits equal `DEV_ADDR` is acknowledged. On any other value the slave gives no acknowledge and ignores the bus, writes included, until the next start.
- R2: After a write-flagged device address, the next byte is a register-select byte. Its bit 7 must be 1, bit 6 is the mode (1 = step, 0 = paired), and bits 3:0 are the pointer. If bit 7 is 0, the byte is not acknowledged and the bus is ignored until the next start.
- R3: In step mode, each data byte written is stored at the pointer, and the pointer then advances by one.
- R4: In paired mode, a data byte is stored at the pointer and the pointer stays put. The byte that follows is taken as a new register-select byte.
- R5: In step mode, the first read after a register-select byte returns the register at the pointer. Each later read first advances the pointer and then returns that register.
- R6: In paired mode, every read returns the register at the unchanged pointer.
- R7: Bytes move most significant bit first on clocks 1 to 8. On clock 9 the slave holds the line low for the whole high phase to acknowledge a received byte. After sending a read byte, it releases the line on clock 9.
- R8: If the master leaves the line high on clock 9 after a read byte, the read burst ends and the slave stays released until the next start.
- R9: A start or repeated start at any point, including in the middle of a byte, restarts byte reception at the device address. A partly received byte is dropped, and the pointer and mode are kept.
- R10: The pointer wraps from 15 to 0 when it advances.
- R11: After reset all registers hold 0x00 and the data line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; bus lines are oversampled on it |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench builds the block with its defaults: device address 0x2C and a two-stage input synchronizer. Each bus half-period lasts eight system clocks, so the synchronizer delay sits well inside one bus phase. The bench models the open-drain line as the AND of the master's level and the slave's release. This lets it reach the register-select byte in both modes and the pointer wrap at register 15. It also covers a foreign device address, a select byte with bit 7 clear, a master not-acknowledge, and a repeated start cut into a half-sent data byte.

// File: rtl/ssreg_pkg.sv
// Shared constants and types for the two-wire register bank slave.
// Assumes a bank of sixteen byte-wide registers addressed by a 4-bit pointer.
package ssreg_pkg;
    localparam int REG_COUNT = 16;
    localparam int BYTE_W    = 8;
    localparam int PTR_W     = $clog2(REG_COUNT);
    localparam int CNT_W     = 4;

    // Byte-level phase of a transfer
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEVADDR,
        PH_REGSEL,
        PH_WRDATA,
        PH_RDDATA
    } phase_t;
endpackage

// File: rtl/ssreg_line_sampler.sv
// Synchronizes the bus clock and data lines and turns them into single-cycle
// events: clock rise, clock fall, start and stop.
// Assumes each bus phase lasts several system clocks.
module ssreg_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_prev;
    logic                   sda_prev;

    // Shift both lines through the synchronizer and keep the previous level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_prev <= scl_pipe[SYNC_STAGES-1];
            sda_prev <= sda_pipe[SYNC_STAGES-1];
        end
    end

    // Decode line events from the current and previous synchronized levels
    always_comb begin
        scl_lvl   = scl_pipe[SYNC_STAGES-1];
        sda_lvl   = sda_pipe[SYNC_STAGES-1];
        scl_rise  = scl_lvl && !scl_prev;
        scl_fall  = !scl_lvl && scl_prev;
        bus_start = scl_lvl && scl_prev && sda_prev && !sda_lvl;
        bus_stop  = scl_lvl && scl_prev && !sda_prev && sda_lvl;
    end

    // R9: start and stop are only seen while the clock is held high
    p_start_clock_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |-> (scl_lvl && $past(scl_lvl)));

    // R7: at most one line event per cycle
    p_single_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_start, bus_stop, scl_rise, scl_fall}));
endmodule

// File: rtl/ssreg_bank.sv
// Register bank: one synchronous write port and one combinational read port.
// Assumes a power-of-two register count so the pointer wraps naturally.
module ssreg_bank #(
    parameter int REG_COUNT = ssreg_pkg::REG_COUNT,
    parameter int BYTE_W    = ssreg_pkg::BYTE_W,
    localparam int PTR_W    = $clog2(REG_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [BYTE_W-1:0] rd_data
);
    logic [REG_COUNT-1:0][BYTE_W-1:0] store;

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
        // Hold one register; clear on reset, load when addressed by a write
        always_ff @(posedge clk) begin
            if (!rst_n)
                store[g] <= '0;
            else if (wr_en && (wr_ptr == PTR_W'(g)))
                store[g] <= wr_data;
        end
    end

    // Return the register selected by the read pointer
    always_comb rd_data = store[rd_ptr];

    // R4: contents change only in a cycle after a write strobe
    p_store_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(store));
endmodule

// File: rtl/ssreg_byte_engine.sv
// Byte-level protocol engine: counts bus clocks, shifts bytes in and out,
// decodes device-address / register-select / data bytes, owns the pointer
// and mode bit, and decides when to pull the data line low.
// Assumes events from ssreg_line_sampler, one per cycle at most.
module ssreg_byte_engine
    import ssreg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_ptr,
    output logic [BYTE_W-1:0] wr_data,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic              sda_pull
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W + 1);

    phase_t            phase;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_shift;
    logic [BYTE_W-1:0] tx_shift;
    logic [PTR_W-1:0]  ptr;
    logic              step_mode;
    logic              first_rd;
    logic              mstr_nack;
    logic              byte_done;
    logic              slot_done;

    // Byte boundaries: fall after bit 8, fall after the acknowledge clock
    always_comb begin
        byte_done = scl_fall && (bit_cnt == LAST_BIT);
        slot_done = scl_fall && (bit_cnt == ACK_SLOT);
    end

    // Write port and read-fetch address for the bank
    always_comb begin
        wr_en   = byte_done && (phase == PH_WRDATA);
        wr_ptr  = ptr;
        wr_data = rx_shift;
        rd_ptr  = (step_mode && !first_rd) ? ptr + 1'b1 : ptr;
    end

    // Protocol sequencing: bit counting, byte decode, pointer and line drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            bit_cnt   <= '0;
            rx_shift  <= '0;
            tx_shift  <= '0;
            ptr       <= '0;
            step_mode <= 1'b0;
            first_rd  <= 1'b1;
            mstr_nack <= 1'b0;
            sda_pull  <= 1'b0;
        end else if (bus_start) begin
            phase    <= PH_DEVADDR;
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
        end else if (bus_stop) begin
            phase    <= PH_IDLE;
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
        end else if (phase != PH_IDLE) begin
            if (scl_rise) begin
                if (bit_cnt < LAST_BIT)
                    rx_shift <= {rx_shift[BYTE_W-2:0], sda_lvl};
                else
                    mstr_nack <= sda_lvl;
                bit_cnt <= bit_cnt + 1'b1;
            end else if (byte_done) begin
                unique case (phase)
                    PH_DEVADDR: begin
                        if (rx_shift[7:1] == DEV_ADDR) begin
                            sda_pull <= 1'b1;
                            phase    <= rx_shift[0] ? PH_RDDATA : PH_REGSEL;
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                    PH_REGSEL: begin
                        if (rx_shift[7]) begin
                            sda_pull  <= 1'b1;
                            ptr       <= rx_shift[PTR_W-1:0];
                            step_mode <= rx_shift[6];
                            first_rd  <= 1'b1;
                            phase     <= PH_WRDATA;
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                    PH_WRDATA: begin
                        sda_pull <= 1'b1;
                        if (step_mode)
                            ptr <= ptr + 1'b1;
                        else
                            phase <= PH_REGSEL;
                    end
                    PH_RDDATA: sda_pull <= 1'b0;
                    default:   phase <= PH_IDLE;
                endcase
            end else if (slot_done) begin
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
                if (phase == PH_RDDATA) begin
                    if (!mstr_nack) begin
                        ptr      <= rd_ptr;
                        tx_shift <= rd_data;
                        sda_pull <= ~rd_data[BYTE_W-1];
                        first_rd <= 1'b0;
                    end else begin
                        phase <= PH_IDLE;
                    end
                end
            end else if (scl_fall && (phase == PH_RDDATA) && (bit_cnt != '0)) begin
                tx_shift <= {tx_shift[BYTE_W-2:0], 1'b0};
                sda_pull <= ~tx_shift[BYTE_W-2];
            end
        end
    end

    // R8: an idle slave never pulls the line
    p_idle_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !sda_pull);

    // R7: line drive only changes while the bus clock is low (or on start/stop)
    p_pull_steady_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl) && !$past(bus_start) && !$past(bus_stop))
            |-> $stable(sda_pull));

    // R3: a stored data byte is always acknowledged
    p_write_acked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> sda_pull);

    // R10: outside a register-select load the pointer only steps by one, wrapping
    p_ptr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((ptr != $past(ptr)) && ($past(phase) != PH_REGSEL))
            |-> (ptr == PTR_W'($past(ptr) + 1'b1)));

    // R7: the bit counter never passes the acknowledge slot
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= ACK_SLOT);
endmodule

// File: rtl/regbank_serial_slave.sv
// Top level of the two-wire register bank slave: line sampler, byte engine
// and register bank. Assumes the data line input is the wired-AND level and
// that sda_pull_o feeds an open-drain pad outside this block.
module regbank_serial_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h2C,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o
);
    import ssreg_pkg::*;

    logic              scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [BYTE_W-1:0] wr_data, rd_data;

    ssreg_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop)
    );

    ssreg_byte_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .bus_start(bus_start),
        .bus_stop(bus_stop), .rd_data(rd_data), .wr_en(wr_en),
        .wr_ptr(wr_ptr), .wr_data(wr_data), .rd_ptr(rd_ptr),
        .sda_pull(sda_pull_o)
    );

    ssreg_bank #(.REG_COUNT(REG_COUNT), .BYTE_W(BYTE_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ptr(wr_ptr),
        .wr_data(wr_data), .rd_ptr(rd_ptr), .rd_data(rd_data)
    );
endmodule

// File: tb/tb_regbank_serial_slave.sv
// Directed bench: a bus master built from tasks drives the open-drain line,
// one task per scenario, each checking its own results.
module tb_regbank_serial_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HP         = 8;
    localparam logic [7:0] DEV_W = 8'h58;
    localparam logic [7:0] DEV_R = 8'h59;
    localparam logic [7:0] BAD_W = 8'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic sda_line;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    regbank_serial_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(HP);
        scl_m = 1'b1; tick(HP);
        sda_m = 1'b0; tick(HP);
        scl_m = 1'b0; tick(HP);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(HP);
        scl_m = 1'b1; tick(HP);
        sda_m = 1'b1; tick(HP);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tick(HP);
            scl_m = 1'b1; tick(HP);
            scl_m = 1'b0; tick(1);
        end
    endtask

    // Send a byte; returns 1 when the slave held the line low through clock 9
    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic early, late;
        send_bits(b, 8);
        sda_m = 1'b1; tick(HP);
        scl_m = 1'b1; tick(1);
        early = sda_line; tick(HP - 2);
        late  = sda_line; tick(1);
        scl_m = 1'b0; tick(1);
        check8("R7 acknowledge level steady over high phase", {7'd0, late}, {7'd0, early});
        acked = !early && !late;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(HP);
            scl_m = 1'b1; tick(HP/2);
            b[i] = sda_line; tick(HP/2);
            scl_m = 1'b0;
        end
        sda_m = ~give_ack; tick(HP);
        scl_m = 1'b1; tick(HP/2);
        if (!give_ack)
            check8("R7 slave releases line on clock 9 of a read", {7'd0, sda_line}, 8'h01);
        tick(HP/2);
        scl_m = 1'b0; tick(2);
        sda_m = 1'b1;
    endtask

    task automatic expect_ack(input logic [7:0] b, input logic exp, input string tag);
        logic a;
        send_byte(b, a);
        check8(tag, {7'd0, a}, {7'd0, exp});
    endtask

    task automatic open_read(input logic [7:0] sel);
        bus_start();
        expect_ack(DEV_W, 1'b1, "R1 device write address acknowledged");
        expect_ack(sel, 1'b1, "R2 register-select byte acknowledged");
        bus_start();
        expect_ack(DEV_R, 1'b1, "R1 device read address acknowledged");
    endtask

    task automatic read_one(input logic [7:0] sel, input logic [7:0] exp, input string tag);
        logic [7:0] v;
        open_read(sel);
        recv_byte(1'b0, v);
        check8(tag, v, exp);
        bus_stop();
    endtask

    task automatic t_reset();
        check8("R11 line released after reset", {7'd0, sda_pull}, 8'h00);
        read_one(8'h80, 8'h00, "R11 register 0 clear after reset");
        read_one(8'h8F, 8'h00, "R11 register 15 clear after reset");
    endtask

    task automatic t_step_write_read();
        logic [7:0] v;
        bus_start();
        expect_ack(DEV_W, 1'b1, "R1 matching address acknowledged");
        expect_ack(8'hC2, 1'b1, "R2 step-mode select byte acknowledged");
        expect_ack(8'hA1, 1'b1, "R3 data byte 1 acknowledged");
        expect_ack(8'hB2, 1'b1, "R3 data byte 2 acknowledged");
        expect_ack(8'hC3, 1'b1, "R3 data byte 3 acknowledged");
        bus_stop();
        open_read(8'hC2);
        recv_byte(1'b1, v); check8("R5 first read uses pointer unchanged", v, 8'hA1);
        recv_byte(1'b1, v); check8("R5 second read pre-increments (R3 reg3)", v, 8'hB2);
        recv_byte(1'b0, v); check8("R5 third read pre-increments (R3 reg4)", v, 8'hC3);
        bus_stop();
    endtask

    task automatic t_paired();
        logic [7:0] v;
        bus_start();
        expect_ack(DEV_W, 1'b1, "R1 matching address acknowledged");
        expect_ack(8'h87, 1'b1, "R2 paired-mode select byte acknowledged");
        expect_ack(8'h55, 1'b1, "R4 data byte acknowledged");
        expect_ack(8'h89, 1'b1, "R4 following byte taken as select");
        expect_ack(8'h66, 1'b1, "R4 second data byte acknowledged");
        bus_stop();
        open_read(8'h87);
        recv_byte(1'b1, v); check8("R6 paired read 1 from register 7", v, 8'h55);
        recv_byte(1'b1, v); check8("R6 paired read 2 same register", v, 8'h55);
        recv_byte(1'b0, v); check8("R6 paired read 3 same register", v, 8'h55);
        bus_stop();
        read_one(8'h89, 8'h66, "R4 register 9 written after re-select");
        read_one(8'h88, 8'h00, "R4 pointer not advanced, register 8 untouched");
    endtask

    task automatic t_wrap();
        logic [7:0] v;
        bus_start();
        expect_ack(DEV_W, 1'b1, "R1 matching address acknowledged");
        expect_ack(8'hCF, 1'b1, "R2 select register 15 step mode");
        expect_ack(8'h11, 1'b1, "R10 write register 15");
        expect_ack(8'h22, 1'b1, "R10 write after wrap");
        bus_stop();
        open_read(8'hCF);
        recv_byte(1'b1, v); check8("R10 register 15", v, 8'h11);
        recv_byte(1'b0, v); check8("R10 read wraps to register 0", v, 8'h22);
        bus_stop();
    endtask

    task automatic t_foreign_address();
        bus_start();
        expect_ack(BAD_W, 1'b0, "R1 foreign address not acknowledged");
        expect_ack(8'hC3, 1'b0, "R1 bus ignored after foreign address");
        expect_ack(8'h99, 1'b0, "R1 data ignored after foreign address");
        bus_stop();
        read_one(8'h83, 8'hB2, "R1 register 3 unchanged by foreign transfer");
    endtask

    task automatic t_bad_select();
        bus_start();
        expect_ack(DEV_W, 1'b1, "R1 matching address acknowledged");
        expect_ack(8'h45, 1'b0, "R2 select with bit 7 clear not acknowledged");
        expect_ack(8'h77, 1'b0, "R2 bus ignored after bad select");
        bus_stop();
        read_one(8'h85, 8'h00, "R2 register 5 not written");
        read_one(8'h87, 8'h55, "R2 register 7 not written");
    endtask

    task automatic t_master_nack();
        logic [7:0] v;
        open_read(8'hC2);
        recv_byte(1'b0, v); check8("R8 read before not-acknowledge", v, 8'hA1);
        recv_byte(1'b0, v); check8("R8 slave silent after not-acknowledge", v, 8'hFF);
        check8("R8 line released", {7'd0, sda_pull}, 8'h00);
        bus_stop();
    endtask

    task automatic t_restart();
        logic [7:0] v;
        open_read(8'hC3);
        recv_byte(1'b1, v); check8("R9 read after repeated start keeps pointer", v, 8'hB2);
        recv_byte(1'b0, v); check8("R9 read after repeated start keeps mode", v, 8'hC3);
        bus_stop();
        bus_start();
        expect_ack(DEV_W, 1'b1, "R1 matching address acknowledged");
        expect_ack(8'hC4, 1'b1, "R2 select register 4");
        send_bits(8'h00, 3);
        bus_start();
        expect_ack(DEV_W, 1'b1, "R9 address accepted after mid-byte restart");
        expect_ack(8'hCA, 1'b1, "R9 select accepted after restart");
        expect_ack(8'h3C, 1'b1, "R9 data accepted after restart");
        bus_stop();
        read_one(8'h8A, 8'h3C, "R9 register 10 written after restart");
        read_one(8'h84, 8'hC3, "R9 partial byte dropped, register 4 kept");
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(4);
        t_reset();
        t_step_write_read();
        t_paired();
        t_wrap();
        t_foreign_address();
        t_bad_select();
        t_master_nack();
        t_restart();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule